// File: doc/BRIEF.md
# Overridable General-Purpose I/O Port

This block is a port of N general-purpose pins. Software owns two bit vectors, a direction vector and an output-data vector. It writes them through a small strobe bus and reads them back through a select-driven read mux. For each pin, peripheral modules can take over any control path with an enable/value pair: the pull-up, the driver enable, the driven value and the digital input enable. A peripheral can also ask for the stored output bit to be inverted.

For every pin the block resolves four controls: driver enable, driven value, pull-up enable and input enable. The pad input is gated by the input enable and offered raw to peripherals. The gated input also passes through a falling-edge stage and a rising-edge stage into a readable pin register. The global sleep state and the global pull-up disable are shared by all pins, and so is the bus.

Top module: `gpio_ovr_port`

## Requirements
- R1: While rst_ni is low, and on its release, the direction and output-data vectors are zero. The pin register is zero, every drv_en_o bit is 0, and every pull_en_o bit without a pull-up override is 0.
- R2: A rising edge with wr_dir_i high loads wdata_i into the direction vector. A rising edge with wr_port_i high loads wdata_i into the output-data vector. rdata_o returns the direction vector for rd_sel_i=0, the output-data vector for 1, the pin register for 2 and zero for 3. Reads return the stored bits, never the overridden values.
- R3: drv_en_o[i] equals dir_ovr_val_i[i] when dir_ovr_en_i[i] is 1. Otherwise it equals direction bit i.
- R4: drv_val_o[i] equals out_ovr_val_i[i] when out_ovr_en_i[i] is 1. Otherwise it equals output-data bit i.
- R5: With pu_ovr_en_i[i] at 0, pull_en_o[i] is 1 exactly when direction bit i is 0, output-data bit i is 1 and pud_i is 0.
- R6: With pu_ovr_en_i[i] at 1, pull_en_o[i] equals pu_ovr_val_i[i], whatever the direction bit, data bit or pud_i.
- R7: On each rising edge, output-data bit i is inverted once if tgl_ovr_en_i[i] is 1 or if wr_pin_i is high with wdata_i[i] at 1. The inversion applies after any same-edge wr_port_i load, and two requests for the same bit still invert it once.
- R8: in_en_o[i] equals ie_ovr_val_i[i] when ie_ovr_en_i[i] is 1. Otherwise it is the inverse of sleep_i.
- R9: din_o[i] is pad_i[i] AND in_en_o[i], combinationally, so a disabled input reads 0.
- R10: The pin register captures din_o on the falling clock edge and moves it to the readable register on the next rising edge. A change made after a falling edge therefore reaches rdata_o (rd_sel_i=2) only after the second rising edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep state, shared |
| pud_i | input | 1 | Global pull-up disable |
| wdata_i | input | N | Bus write data |
| wr_dir_i | input | 1 | Write strobe, direction vector |
| wr_port_i | input | 1 | Write strobe, output-data vector |
| wr_pin_i | input | 1 | Write strobe, invert output-data bits set in wdata_i |
| rd_sel_i | input | 2 | Read select: 0 direction, 1 data, 2 pin, 3 zero |
| rdata_o | output | N | Read data |
| pu_ovr_en_i | input | N | Pull-up override enable per pin |
| pu_ovr_val_i | input | N | Pull-up override value per pin |
| dir_ovr_en_i | input | N | Driver-enable override enable per pin |
| dir_ovr_val_i | input | N | Driver-enable override value per pin |
| out_ovr_en_i | input | N | Output-value override enable per pin |
| out_ovr_val_i | input | N | Output-value override value per pin |
| tgl_ovr_en_i | input | N | Output-data invert request per pin |
| ie_ovr_en_i | input | N | Input-enable override enable per pin |
| ie_ovr_val_i | input | N | Input-enable override value per pin |
| pad_i | input | N | Pad input level |
| drv_en_o | output | N | Resolved output driver enable |
| drv_val_o | output | N | Resolved driven value |
| pull_en_o | output | N | Resolved pull-up enable |
| in_en_o | output | N | Resolved digital input enable |
| din_o | output | N | Gated, unsynchronized input to peripherals |

## Verification
The output-data vector can receive a bus load, a bus invert and a peripheral invert request on the same rising edge. The bench drives wr_port_i or wr_pin_i together with tgl_ovr_en_i, using overlapping and disjoint bit masks. It then reads the vector back and compares it with the load value XOR the union of the invert masks. Holding the toggle request over several edges confirms one inversion per edge.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  typedef enum logic [1:0] {
    RD_DIR  = 2'd0,
    RD_DATA = 2'd1,
    RD_PIN  = 2'd2,
    RD_NONE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic pu_en;
    logic pu_val;
    logic dir_en;
    logic dir_val;
    logic out_en;
    logic out_val;
    logic ie_en;
    logic ie_val;
  } pin_ovr_t;

endpackage

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_ovr_pkg::*;
(
  input  logic     dir_i,
  input  logic     data_i,
  input  logic     pud_i,
  input  logic     sleep_i,
  input  pin_ovr_t ovr_i,
  input  logic     pad_i,
  output logic     drv_en_o,
  output logic     drv_val_o,
  output logic     pull_en_o,
  output logic     in_en_o,
  output logic     din_o
);

  logic pull_norm;

  // default pull-up: input direction, data bit high, not globally disabled
  assign pull_norm = ({dir_i, data_i, pud_i} == 3'b010);

  always_comb begin
    drv_en_o  = ovr_i.dir_en ? ovr_i.dir_val : dir_i;
    drv_val_o = ovr_i.out_en ? ovr_i.out_val : data_i;
    pull_en_o = ovr_i.pu_en  ? ovr_i.pu_val  : pull_norm;
    in_en_o   = ovr_i.ie_en  ? ovr_i.ie_val  : ~sleep_i;
  end

  // disabled input presents 0 so a floating pad cannot toggle logic
  assign din_o = pad_i & in_en_o;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] wdata_i,
  input  logic         wr_dir_i,
  input  logic         wr_port_i,
  input  logic         wr_pin_i,
  input  logic [N-1:0] tgl_i,
  output logic [N-1:0] dir_o,
  output logic [N-1:0] data_o
);

  logic [N-1:0] dir_q, dir_d;
  logic [N-1:0] data_q, data_d, base, flip;

  always_comb begin
    dir_d  = wr_dir_i ? wdata_i : dir_q;
    base   = wr_port_i ? wdata_i : data_q;
    flip   = tgl_i | (wr_pin_i ? wdata_i : '0);
    data_d = base ^ flip;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      dir_q  <= dir_d;
      data_q <= data_d;
    end
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;

  p_reset_clear_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (dir_q == '0) && (data_q == '0));

  p_dir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> dir_q == $past(dir_q));

  p_toggle_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_port_i && !wr_pin_i) |=> data_q == ($past(data_q) ^ $past(tgl_i)));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  output logic [N-1:0] pin_o
);

  logic [N-1:0] half_q, pin_q;

  // half-cycle capture stage on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= '0;
    else         half_q <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= half_q;
  end

  assign pin_o = pin_q;

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_i,
  input  logic         pud_i,
  input  logic [N-1:0] wdata_i,
  input  logic         wr_dir_i,
  input  logic         wr_port_i,
  input  logic         wr_pin_i,
  input  logic [1:0]   rd_sel_i,
  output logic [N-1:0] rdata_o,
  input  logic [N-1:0] pu_ovr_en_i,
  input  logic [N-1:0] pu_ovr_val_i,
  input  logic [N-1:0] dir_ovr_en_i,
  input  logic [N-1:0] dir_ovr_val_i,
  input  logic [N-1:0] out_ovr_en_i,
  input  logic [N-1:0] out_ovr_val_i,
  input  logic [N-1:0] tgl_ovr_en_i,
  input  logic [N-1:0] ie_ovr_en_i,
  input  logic [N-1:0] ie_ovr_val_i,
  input  logic [N-1:0] pad_i,
  output logic [N-1:0] drv_en_o,
  output logic [N-1:0] drv_val_o,
  output logic [N-1:0] pull_en_o,
  output logic [N-1:0] in_en_o,
  output logic [N-1:0] din_o
);

  logic [N-1:0] dir_q, data_q, pin_q;

  gpio_port_regs #(.N(N)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (wdata_i),
    .wr_dir_i  (wr_dir_i),
    .wr_port_i (wr_port_i),
    .wr_pin_i  (wr_pin_i),
    .tgl_i     (tgl_ovr_en_i),
    .dir_o     (dir_q),
    .data_o    (data_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    pin_ovr_t ovr;

    assign ovr = '{pu_en:   pu_ovr_en_i[i],  pu_val:  pu_ovr_val_i[i],
                   dir_en:  dir_ovr_en_i[i], dir_val: dir_ovr_val_i[i],
                   out_en:  out_ovr_en_i[i], out_val: out_ovr_val_i[i],
                   ie_en:   ie_ovr_en_i[i],  ie_val:  ie_ovr_val_i[i]};

    gpio_pin_resolve u_res (
      .dir_i     (dir_q[i]),
      .data_i    (data_q[i]),
      .pud_i     (pud_i),
      .sleep_i   (sleep_i),
      .ovr_i     (ovr),
      .pad_i     (pad_i[i]),
      .drv_en_o  (drv_en_o[i]),
      .drv_val_o (drv_val_o[i]),
      .pull_en_o (pull_en_o[i]),
      .in_en_o   (in_en_o[i]),
      .din_o     (din_o[i])
    );

    p_drv_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dir_ovr_en_i[i] |-> drv_en_o[i] == dir_q[i]);

    p_pull_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pu_ovr_en_i[i] && (dir_q[i] || !data_q[i] || pud_i)) |-> !pull_en_o[i]);

    p_pull_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pu_ovr_en_i[i] |-> pull_en_o[i] == pu_ovr_val_i[i]);

    p_sleep_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ie_ovr_en_i[i] && sleep_i) |-> (!in_en_o[i] && !din_o[i]));
  end

  gpio_in_sync #(.N(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din_o),
    .pin_o  (pin_q)
  );

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      RD_DIR:  rdata_o = dir_q;
      RD_DATA: rdata_o = data_q;
      RD_PIN:  rdata_o = pin_q;
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: tb/gpio_ovr_port_test.sv
module gpio_ovr_port_test;
  localparam int N = 8;

  typedef struct packed {
    logic [7:0] dir, data, pu_en, pu_val, dd_en, dd_val, pv_en, pv_val,
                ie_en, ie_val, pad, pud, slp;
  } vec_t;

  localparam int NV = 6;
  localparam logic [103:0] VECS [NV] = '{
    {8'h00,8'hFF,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'hA5,8'h00,8'h00},
    {8'hF0,8'hCC,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h3C,8'h01,8'h00},
    {8'h0F,8'hAA,8'hF0,8'h5A,8'h33,8'h96,8'h0F,8'hC3,8'h00,8'h00,8'hFF,8'h00,8'h01},
    {8'h55,8'h33,8'hFF,8'h0F,8'hFF,8'hF0,8'hFF,8'h3C,8'hF0,8'hA0,8'hFF,8'h00,8'h01},
    {8'hFF,8'h5A,8'h00,8'h00,8'h00,8'h00,8'hF0,8'h0F,8'h0F,8'h00,8'h69,8'h00,8'h00},
    {8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'hFF,8'hFF,8'hC3,8'h01,8'h01}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, sleep_i = 1'b0, pud_i = 1'b0;
  logic [N-1:0] wdata_i = '0;
  logic wr_dir_i = 1'b0, wr_port_i = 1'b0, wr_pin_i = 1'b0;
  logic [1:0] rd_sel_i = 2'd0;
  logic [N-1:0] rdata_o;
  logic [N-1:0] pu_ovr_en_i = '0, pu_ovr_val_i = '0, dir_ovr_en_i = '0, dir_ovr_val_i = '0;
  logic [N-1:0] out_ovr_en_i = '0, out_ovr_val_i = '0, tgl_ovr_en_i = '0;
  logic [N-1:0] ie_ovr_en_i = '0, ie_ovr_val_i = '0, pad_i = '0;
  logic [N-1:0] drv_en_o, drv_val_o, pull_en_o, in_en_o, din_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  gpio_ovr_port #(.N(N)) uut (
    .clk_i, .rst_ni, .sleep_i, .pud_i, .wdata_i, .wr_dir_i, .wr_port_i, .wr_pin_i,
    .rd_sel_i, .rdata_o, .pu_ovr_en_i, .pu_ovr_val_i, .dir_ovr_en_i, .dir_ovr_val_i,
    .out_ovr_en_i, .out_ovr_val_i, .tgl_ovr_en_i, .ie_ovr_en_i, .ie_ovr_val_i,
    .pad_i, .drv_en_o, .drv_val_o, .pull_en_o, .in_en_o, .din_o
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic rd(input logic [1:0] sel, input string req, input logic [N-1:0] exp);
    rd_sel_i = sel;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic wr(input int kind, input logic [N-1:0] d);
    wdata_i = d;
    wr_dir_i  = (kind == 0);
    wr_port_i = (kind == 1);
    wr_pin_i  = (kind == 2);
    tick();
    wr_dir_i = 1'b0; wr_port_i = 1'b0; wr_pin_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [N-1:0] ie, pl, dv, tmp;
    // reset state (R1)
    #12;
    chk("R1 drv_en", drv_en_o, '0);
    chk("R1 pull_en", pull_en_o, '0);
    rd(2'd0, "R1 dir", '0);
    rd(2'd1, "R1 data", '0);
    rd(2'd2, "R1 pin", '0);
    tick();
    rst_ni = 1'b1;
    tick();
    rd(2'd3, "R2 sel3 zero", '0);

    // vector table (R2..R6, R8, R9, R10)
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = vec_t'(VECS[k]);
      wr(0, v.dir);
      wr(1, v.data);
      pud_i = v.pud[0]; sleep_i = v.slp[0];
      pu_ovr_en_i = v.pu_en; pu_ovr_val_i = v.pu_val;
      dir_ovr_en_i = v.dd_en; dir_ovr_val_i = v.dd_val;
      out_ovr_en_i = v.pv_en; out_ovr_val_i = v.pv_val;
      ie_ovr_en_i = v.ie_en; ie_ovr_val_i = v.ie_val;
      pad_i = v.pad;
      #1;
      ie = (v.ie_en & v.ie_val) | (~v.ie_en & {N{~v.slp[0]}});
      pl = (v.pu_en & v.pu_val) | (~v.pu_en & ~v.dir & v.data & {N{~v.pud[0]}});
      dv = (v.dd_en & v.dd_val) | (~v.dd_en & v.dir);
      chk("R3 drv_en", drv_en_o, dv);
      chk("R4 drv_val", drv_val_o, (v.pv_en & v.pv_val) | (~v.pv_en & v.data));
      chk(v.pu_en == '0 ? "R5 pull" : "R6 pull", pull_en_o, pl);
      chk("R8 in_en", in_en_o, ie);
      chk("R9 din", din_o, v.pad & ie);
      rd(2'd0, "R2 dir readback", v.dir);
      rd(2'd1, "R2 data readback", v.data);
      tick(); tick();
      rd(2'd2, "R10 pin", v.pad & ie);
    end

    // clear overrides
    pu_ovr_en_i = '0; dir_ovr_en_i = '0; out_ovr_en_i = '0; ie_ovr_en_i = '0;
    sleep_i = 1'b0; pud_i = 1'b0;

    // R7: held toggle inverts once per edge
    wr(1, 8'h3C);
    tgl_ovr_en_i = 8'h0F;
    tick();
    rd(2'd1, "R7 toggle 1", 8'h33);
    tick();
    rd(2'd1, "R7 toggle 2", 8'h3C);
    tgl_ovr_en_i = '0;
    tick();
    rd(2'd1, "R7 toggle released", 8'h3C);

    // R7: bus load and toggle on the same edge
    tgl_ovr_en_i = 8'hF0;
    wr(1, 8'h81);
    tgl_ovr_en_i = '0;
    rd(2'd1, "R7 load+toggle", 8'h71);

    // R7: bus invert and toggle, overlapping masks invert once
    tgl_ovr_en_i = 8'h0C;
    wr(2, 8'h06);
    tgl_ovr_en_i = '0;
    rd(2'd1, "R7 invert+toggle", 8'h7F);

    // R7: bus invert alone
    wr(2, 8'h80);
    rd(2'd1, "R7 bus invert", 8'hFF);

    // R10 latency: change after rising edge, before falling edge
    pad_i = 8'h00;
    tick(); tick();
    rd(2'd2, "R10 settle", 8'h00);
    pad_i = 8'hA5;
    rd(2'd2, "R10 same cycle old", 8'h00);
    tick();
    rd(2'd2, "R10 one edge", 8'hA5);

    // R10: change after falling edge needs two rising edges
    #5;
    pad_i = 8'h5A;
    tick();
    rd(2'd2, "R10 after fall, first edge", 8'hA5);
    tick();
    rd(2'd2, "R10 after fall, second edge", 8'h5A);

    // R8/R10: sleep blocks input, pin register reads 0
    sleep_i = 1'b1;
    #1;
    chk("R9 din sleep", din_o, '0);
    tick(); tick();
    rd(2'd2, "R10 pin in sleep", '0);
    sleep_i = 1'b0;

    // R1: reset mid-run
    wr(0, 8'hFF);
    wr(1, 8'hFF);
    rst_ni = 1'b0;
    #1;
    rd(2'd0, "R1 dir mid reset", '0);
    rd(2'd1, "R1 data mid reset", '0);
    rd(2'd2, "R1 pin mid reset", '0);
    chk("R1 drv_en mid reset", drv_en_o, '0);
    chk("R1 pull off in reset", pull_en_o, '0);
    tick();
    rst_ni = 1'b1;
    tick();
    tmp = '0;
    rd(2'd0, "R1 dir after release", tmp);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule